// File: doc/BRIEF.md
# Cascadable Up/Down Event Counter Pair

This block holds two 8-bit counters that step one position per cycle on up and down strobes. Each counter has one reload/compare register. A single value in that register does two jobs: it is the target the counter is compared against after every step, and it is the value loaded back when the counter runs past its top. Four sticky event flags sit beside each counter. They record a reversal of counting direction, a compare hit, an overflow and an underflow. Each flag stays set until software writes 0 to it. Three per-counter enable bits select which causes drive that counter's interrupt request.

Software reaches every register through a single-cycle write port and a combinational read port. A mode bit joins the two counters into one 16-bit counter. In that mode channel 0's strobes drive the counter, and channel 0's enables, flags and interrupt line serve the joined pair. Channel 1's strobes and interrupt line are silenced while the counters are joined. The interrupt requests go to an external interrupt controller.

Top module: `updown_pair`

## Requirements
- R1: Synchronous active-high reset clears both counters, both reload/compare registers, all enable bits, all flags and the mode bit; both interrupt lines are low after reset.
- R2: In one cycle an up strobe alone adds 1 to the counter and a down strobe alone subtracts 1; with both strobes or neither the counter holds its value.
- R3: An up step from the all-ones value (0xFF per channel, 0xFFFF when joined) loads the reload/compare value and sets the overflow flag (control bit 10).
- R4: A down step from 0 wraps the counter to the all-ones value and sets the underflow flag (control bit 11).
- R5: After any step, including the reload on overflow, the compare flag (control bit 9) sets when the new counter value equals the reload/compare value.
- R6: The direction flag (control bit 8) sets on a step whose direction is opposite to that channel's previous step; the first step after reset never sets it.
- R7: Flags are cleared only by a control write with 0 in the flag's bit; a 1 leaves the flag unchanged; a hardware set in the same cycle as a clear leaves the flag set.
- R8: A channel's interrupt line is the OR of direction flag AND enable bit 0, compare flag AND enable bit 1, and (overflow OR underflow) AND enable bit 2.
- R9: Writing a control register with bit 3 set copies the reload/compare value into the counter on that edge; bit 3 always reads back as 0.
- R10: With the mode bit (address 6, bit 0) set, {counter 1, counter 0} is one 16-bit counter with reload {reload 1, reload 0}, stepped by channel 0 strobes with events on channel 0's flags; channel 1 strobes have no effect and interrupt line 1 stays low.
- R11: A software write to a counter, or a load command, takes priority over a strobe in the same cycle: that strobe is dropped and sets no flag (when joined, a write to either half or a load drops the step).
- R12: Register addresses: 0 and 1 counters, 2 and 3 reload/compare values, 4 and 5 control words (enables in bits 2:0, flags in bits 11:8), 6 the mode bit; unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_i | input | 2 | Up strobes, one per channel |
| dn_i | input | 2 | Down strobes, one per channel |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| irq_o | output | 2 | Interrupt request per channel |

## Verification
A wrong counter value can be read back on the cycle after the faulty step. It also shows later, when a compare or overflow event fires at the wrong time or fails to fire. A direction tracker that holds stale state shows only on the next reversal, so the stimulus mixes long single-direction runs with short reversals. Flag or enable faults show at once on the interrupt lines, which are compared every cycle. Joined-mode carry errors show only at the 0x00FF/0x0100 and 0xFFFF boundaries, so directed cases push the joined counter through both ends.

// File: rtl/udc_pkg.sv
package udc_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;

    // control word bit positions
    localparam int EN_DIR   = 0;
    localparam int EN_CMP   = 1;
    localparam int EN_OU    = 2;
    localparam int EN_HI    = 2;
    localparam int LOAD_BIT = 3;
    localparam int F_LO     = 8;
    localparam int F_HI     = 11;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT0 = 3'd0,
        A_CNT1 = 3'd1,
        A_REL0 = 3'd2,
        A_REL1 = 3'd3,
        A_CTL0 = 3'd4,
        A_CTL1 = 3'd5,
        A_MODE = 3'd6
    } reg_addr_e;

    // packed so that dirchg lands on F_LO and udf on F_HI
    typedef struct packed {
        logic udf;
        logic ovf;
        logic cmp;
        logic dirchg;
    } flags_t;

    typedef struct packed {
        logic moved;
        logic up;
        logic ovf;
        logic udf;
        logic cmp;
    } step_ev_t;

    function automatic logic irq_of(input logic [EN_HI:0] en, input flags_t f);
        return (en[EN_DIR] & f.dirchg) | (en[EN_CMP] & f.cmp) |
               (en[EN_OU] & (f.ovf | f.udf));
    endfunction

endpackage

// File: rtl/udc_step.sv
module udc_step
    import udc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] rel_i,
    input  logic         up_i,
    input  logic         dn_i,
    output logic [W-1:0] nxt_o,
    output step_ev_t     ev_o
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_comb begin
        ev_o  = '0;
        nxt_o = cnt_i;
        if (up_i ^ dn_i) begin
            ev_o.moved = 1'b1;
            ev_o.up    = up_i;
            if (up_i) begin
                if (cnt_i == TOP) begin
                    nxt_o    = rel_i;
                    ev_o.ovf = 1'b1;
                end else begin
                    nxt_o = cnt_i + 1'b1;
                end
            end else begin
                if (cnt_i == '0) begin
                    nxt_o    = TOP;
                    ev_o.udf = 1'b1;
                end else begin
                    nxt_o = cnt_i - 1'b1;
                end
            end
            ev_o.cmp = (nxt_o == rel_i);
        end
    end

endmodule

// File: rtl/udc_flags.sv
module udc_flags
    import udc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  step_ev_t       ev_i,
    input  logic           wr_i,
    input  logic [EN_HI:0] en_w_i,
    input  flags_t         flg_w_i,
    output logic [EN_HI:0] en_o,
    output flags_t         flg_o,
    output logic           irq_o
);

    logic   last_up_q;
    logic   seen_q;
    logic   dir_hit;
    flags_t hw_set;
    flags_t kept;
    flags_t flg_nx;

    always_comb begin
        dir_hit       = ev_i.moved & seen_q & (ev_i.up != last_up_q);
        hw_set.dirchg = dir_hit;
        hw_set.cmp    = ev_i.cmp;
        hw_set.ovf    = ev_i.ovf;
        hw_set.udf    = ev_i.udf;
        kept          = wr_i ? (flg_o & flg_w_i) : flg_o;
        flg_nx        = kept | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o      <= '0;
            flg_o     <= '0;
            last_up_q <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            if (wr_i) begin
                en_o <= en_w_i;
            end
            flg_o <= flg_nx;
            if (ev_i.moved) begin
                last_up_q <= ev_i.up;
                seen_q    <= 1'b1;
            end
        end
    end

    assign irq_o = irq_of(en_o, flg_o);

endmodule

// File: rtl/updown_pair.sv
module updown_pair
    import udc_pkg::*;
#(
    parameter int CH_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        up_i,
    input  logic [1:0]        dn_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [2*CH_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [2*CH_W-1:0] rd_data,
    output logic [1:0]        irq_o
);

    localparam int DW  = 2 * CH_W;
    localparam int NCH = 2;

    logic [CH_W-1:0] cnt_q [NCH];
    logic [CH_W-1:0] rel_q [NCH];
    logic [CH_W-1:0] nxt_s [NCH];
    logic            casc_q;

    logic [NCH-1:0] wr_cnt, wr_rel, wr_ctl, ld_cmd, blk, su, sd, irq_f;
    logic           wr_mode, blk_c, wu, wdn;

    logic [DW-1:0]  nxt_w;
    step_ev_t       ev_w;
    step_ev_t       ev_s [NCH];
    step_ev_t       ev_f [NCH];
    logic [EN_HI:0] en_q [NCH];
    flags_t         flg_q [NCH];

    assign wr_mode = wr_en && (reg_addr_e'(wr_addr) == A_MODE);
    assign blk_c   = (|wr_cnt) | (|ld_cmd);
    assign wu      = up_i[0] & casc_q & ~blk_c;
    assign wdn     = dn_i[0] & casc_q & ~blk_c;

    udc_step #(.W(DW)) u_wide (
        .cnt_i ({cnt_q[1], cnt_q[0]}),
        .rel_i ({rel_q[1], rel_q[0]}),
        .up_i  (wu),
        .dn_i  (wdn),
        .nxt_o (nxt_w),
        .ev_o  (ev_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            casc_q <= 1'b0;
        end else if (wr_mode) begin
            casc_q <= wr_data[0];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign wr_cnt[g] = wr_en && (wr_addr == ADDR_W'(int'(A_CNT0) + g));
        assign wr_rel[g] = wr_en && (wr_addr == ADDR_W'(int'(A_REL0) + g));
        assign wr_ctl[g] = wr_en && (wr_addr == ADDR_W'(int'(A_CTL0) + g));
        assign ld_cmd[g] = wr_ctl[g] & wr_data[LOAD_BIT];
        assign blk[g]    = wr_cnt[g] | ld_cmd[g];
        assign su[g]     = up_i[g] & ~casc_q & ~blk[g];
        assign sd[g]     = dn_i[g] & ~casc_q & ~blk[g];

        udc_step #(.W(CH_W)) u_step (
            .cnt_i (cnt_q[g]),
            .rel_i (rel_q[g]),
            .up_i  (su[g]),
            .dn_i  (sd[g]),
            .nxt_o (nxt_s[g]),
            .ev_o  (ev_s[g])
        );

        if (g == 0) begin : g_lo
            assign ev_f[g]  = casc_q ? ev_w : ev_s[g];
            assign irq_o[g] = irq_f[g];
        end else begin : g_hi
            assign ev_f[g]  = casc_q ? step_ev_t'('0) : ev_s[g];
            assign irq_o[g] = irq_f[g] & ~casc_q;
        end

        udc_flags u_flags (
            .clk     (clk),
            .rst     (rst),
            .ev_i    (ev_f[g]),
            .wr_i    (wr_ctl[g]),
            .en_w_i  (wr_data[EN_HI:0]),
            .flg_w_i (flags_t'(wr_data[F_HI:F_LO])),
            .en_o    (en_q[g]),
            .flg_o   (flg_q[g]),
            .irq_o   (irq_f[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '0;
            end else if (wr_cnt[g]) begin
                cnt_q[g] <= wr_data[CH_W-1:0];
            end else if (ld_cmd[g] | (casc_q & (|ld_cmd))) begin
                cnt_q[g] <= rel_q[g];
            end else if (casc_q) begin
                cnt_q[g] <= nxt_w[g*CH_W +: CH_W];
            end else begin
                cnt_q[g] <= nxt_s[g];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rel_q[g] <= '0;
            end else if (wr_rel[g]) begin
                rel_q[g] <= wr_data[CH_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_CNT0: rd_data[CH_W-1:0] = cnt_q[0];
            A_CNT1: rd_data[CH_W-1:0] = cnt_q[1];
            A_REL0: rd_data[CH_W-1:0] = rel_q[0];
            A_REL1: rd_data[CH_W-1:0] = rel_q[1];
            A_CTL0: begin
                rd_data[EN_HI:0]  = en_q[0];
                rd_data[F_HI:F_LO] = flg_q[0];
            end
            A_CTL1: begin
                rd_data[EN_HI:0]  = en_q[1];
                rd_data[F_HI:F_LO] = flg_q[1];
            end
            A_MODE:  rd_data[0] = casc_q;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/udc_chk.sv
module udc_chk
    import udc_pkg::*;
#(
    parameter int CH_W = CNT_W
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        up_i,
    input logic [1:0]        dn_i,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        irq_o,
    input logic              casc_q,
    input logic [CH_W-1:0]   cnt0,
    input logic [CH_W-1:0]   rel0,
    input flags_t            flg0
);

    localparam logic [CH_W-1:0] TOP = {CH_W{1'b1}};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt0 == '0 && flg0 == '0 && irq_o == 2'b00 && !casc_q));

    assert_both_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!casc_q && up_i[0] && dn_i[0] && !wr_en) |=> $stable(cnt0));

    assert_ovf_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (!casc_q && up_i[0] && !dn_i[0] && !wr_en && cnt0 == TOP)
        |=> (flg0.ovf && cnt0 == $past(rel0)));

    assert_udf_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (!casc_q && dn_i[0] && !up_i[0] && !wr_en && cnt0 == '0)
        |=> (flg0.udf && cnt0 == TOP));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_addr_e'(wr_addr) == A_CTL0)
        |=> ((4'(flg0) & 4'($past(flg0))) == 4'($past(flg0))));

    assert_joined_irq_low_R10: assert property (@(posedge clk) disable iff (rst)
        casc_q |-> !irq_o[1]);

endmodule

bind updown_pair udc_chk #(.CH_W(CH_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .up_i    (up_i),
    .dn_i    (dn_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .irq_o   (irq_o),
    .casc_q  (casc_q),
    .cnt0    (cnt_q[0]),
    .rel0    (rel_q[0]),
    .flg0    (flg_q[0])
);

// File: tb/tb_updown_pair.sv
module tb_updown_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  up_i = '0;
    logic [1:0]  dn_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit model_on = 0;

    // requirement-level model state
    int       m_cnt [2];
    int       m_rel [2];
    bit [2:0] m_en  [2];
    bit [3:0] m_flg [2];   // bit0 dir, bit1 cmp, bit2 ovf, bit3 udf
    bit       m_last[2];
    bit       m_seen[2];
    bit       m_casc;

    always #4 clk = ~clk;

    updown_pair dut (
        .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        rd_addr = 3'(a);
        #1;
        chk(tag, int'(rd_data), exp, $sformatf("reg%0d", a));
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_rel[i] = 0; m_en[i] = 0; m_flg[i] = 0;
            m_last[i] = 0; m_seen[i] = 0;
        end
        m_casc = 0;
    endtask

    function automatic void mstep(input int maxv, input int cnt, input int rel,
                                  input bit up, input bit dn, output int nxt,
                                  output bit mv, output bit ovf, output bit udf,
                                  output bit cmp);
        nxt = cnt; mv = 0; ovf = 0; udf = 0; cmp = 0;
        if (up != dn) begin
            mv = 1;
            if (up) begin
                if (cnt == maxv) begin nxt = rel; ovf = 1; end
                else nxt = cnt + 1;
            end else begin
                if (cnt == 0) begin nxt = maxv; udf = 1; end
                else nxt = cnt - 1;
            end
            cmp = (nxt == rel);
        end
    endfunction

    task automatic model_apply(input bit [1:0] up, input bit [1:0] dn, input bit we,
                               input int wa, input int wd);
        int nx[2];
        bit [3:0] hw[2];
        bit load, blkd, mv, o, u, c, dh;
        int w;
        nx[0] = m_cnt[0]; nx[1] = m_cnt[1];
        hw[0] = 0; hw[1] = 0;
        load = we && (wa == 4 || wa == 5) && wd[3];
        if (m_casc) begin
            blkd = (we && (wa == 0 || wa == 1)) || load;
            if (!blkd) begin
                mstep(65535, m_cnt[1] * 256 + m_cnt[0], m_rel[1] * 256 + m_rel[0],
                      up[0], dn[0], w, mv, o, u, c);
                nx[0] = w % 256; nx[1] = w / 256;
                dh = mv && m_seen[0] && (up[0] != m_last[0]);
                hw[0] = {u, o, c, dh};
                if (mv) begin m_last[0] = up[0]; m_seen[0] = 1; end
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                blkd = (we && wa == i) || (load && wa == 4 + i);
                if (!blkd) begin
                    mstep(255, m_cnt[i], m_rel[i], up[i], dn[i], w, mv, o, u, c);
                    nx[i] = w;
                    dh = mv && m_seen[i] && (up[i] != m_last[i]);
                    hw[i] = {u, o, c, dh};
                    if (mv) begin m_last[i] = up[i]; m_seen[i] = 1; end
                end
            end
        end
        if (load) begin
            if (m_casc) begin nx[0] = m_rel[0]; nx[1] = m_rel[1]; end
            else nx[wa - 4] = m_rel[wa - 4];
        end
        if (we) begin
            case (wa)
                0: nx[0] = wd & 255;
                1: nx[1] = wd & 255;
                2: m_rel[0] = wd & 255;
                3: m_rel[1] = wd & 255;
                4, 5: begin
                    m_en[wa - 4]  = 3'(wd);
                    m_flg[wa - 4] = m_flg[wa - 4] & 4'(wd >> 8);
                end
                6: m_casc = wd[0];
                default: ;
            endcase
        end
        for (int i = 0; i < 2; i++) begin
            m_flg[i] = m_flg[i] | hw[i];
            m_cnt[i] = nx[i];
        end
    endtask

    function automatic int exp_reg(input int a);
        case (a)
            0: return m_cnt[0];
            1: return m_cnt[1];
            2: return m_rel[0];
            3: return m_rel[1];
            4: return (int'(m_flg[0]) << 8) | int'(m_en[0]);
            5: return (int'(m_flg[1]) << 8) | int'(m_en[1]);
            6: return int'(m_casc);
            default: return 0;
        endcase
    endfunction

    function automatic int exp_irq();
        bit [1:0] r;
        for (int i = 0; i < 2; i++)
            r[i] = (m_en[i][0] & m_flg[i][0]) | (m_en[i][1] & m_flg[i][1]) |
                   (m_en[i][2] & (m_flg[i][2] | m_flg[i][3]));
        if (m_casc) r[1] = 0;
        return int'(r);
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic cyc(input bit [1:0] up, input bit [1:0] dn, input bit we,
                       input int wa, input int wd);
        up_i = up; dn_i = dn; wr_en = we; wr_addr = 3'(wa); wr_data = 16'(wd);
        if (model_on) model_apply(up, dn, we, wa, wd);
        @(posedge clk);
        @(negedge clk);
        up_i = '0; dn_i = '0; wr_en = 1'b0;
    endtask

    task automatic wreg(input int a, input int d);
        cyc(2'b00, 2'b00, 1'b1, a, d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240517);
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd_chk(0, 0, "R1"); rd_chk(4, 0, "R1"); rd_chk(6, 0, "R1");
        chk("R1", int'(irq_o), 0, "irq");

        // R12 reload register at address 2
        wreg(2, 16'h0005);
        rd_chk(2, 5, "R12");

        // R6 first step after reset, then R2 counting
        cyc(2'b01, 2'b00, 0, 0, 0);
        rd_chk(4, 0, "R6");
        cyc(2'b01, 2'b00, 0, 0, 0);
        cyc(2'b01, 2'b00, 0, 0, 0);
        rd_chk(0, 3, "R2");
        cyc(2'b01, 2'b01, 0, 0, 0);
        rd_chk(0, 3, "R2");
        cyc(2'b00, 2'b01, 0, 0, 0);
        rd_chk(0, 2, "R2");
        rd_chk(4, 16'h0100, "R6");

        // R7 write 1 keeps, write 0 clears
        wreg(4, 16'h0F00);
        rd_chk(4, 16'h0100, "R7");
        wreg(4, 16'h0000);
        rd_chk(4, 16'h0000, "R7");

        // R5 compare hit at 5 (plus direction reversal)
        repeat (3) cyc(2'b01, 2'b00, 0, 0, 0);
        rd_chk(0, 5, "R5");
        rd_chk(4, 16'h0300, "R5");

        // R8 enabling compare raises irq, clearing drops it
        chk("R8", int'(irq_o), 0, "irq before enable");
        wreg(4, 16'h0F02);
        chk("R8", int'(irq_o), 1, "irq cmp enabled");
        wreg(4, 16'h0002);
        chk("R8", int'(irq_o), 0, "irq after clear");

        // R7 hardware set beats software clear
        cyc(2'b00, 2'b01, 1, 4, 16'h0002);
        rd_chk(4, 16'h0102, "R7");
        rd_chk(0, 4, "R7");
        wreg(4, 16'h0002);

        // R9 load command
        wreg(4, 16'h000A);
        rd_chk(0, 5, "R9");
        rd_chk(4, 16'h0002, "R9");

        // R11 counter write beats strobe
        cyc(2'b01, 2'b00, 1, 0, 16'h00FF);
        rd_chk(0, 16'h00FF, "R11");
        rd_chk(4, 16'h0002, "R11");

        // R3 overflow reloads, sets ovf, cmp and dir
        cyc(2'b01, 2'b00, 0, 0, 0);
        rd_chk(0, 5, "R3");
        rd_chk(4, 16'h0702, "R3");
        chk("R8", int'(irq_o), 1, "irq after overflow");
        wreg(4, 0);

        // R4 underflow wraps
        wreg(0, 0);
        cyc(2'b00, 2'b01, 0, 0, 0);
        rd_chk(0, 16'h00FF, "R4");
        rd_chk(4, 16'h0900, "R4");
        wreg(4, 16'h0F04);
        chk("R8", int'(irq_o), 1, "irq ovf/udf enabled");
        wreg(4, 0);

        // R10 joined 16-bit counter
        wreg(6, 1);
        rd_chk(6, 1, "R10");
        wreg(3, 16'h0012);
        wreg(1, 16'h00FF);
        cyc(2'b01, 2'b00, 0, 0, 0);
        rd_chk(0, 16'h0005, "R10");
        rd_chk(1, 16'h0012, "R10");
        rd_chk(4, 16'h0700, "R10");
        cyc(2'b10, 2'b00, 0, 0, 0);
        rd_chk(1, 16'h0012, "R10");
        rd_chk(5, 0, "R10");
        wreg(0, 16'h00FF); wreg(1, 0);
        cyc(2'b01, 2'b00, 0, 0, 0);
        rd_chk(0, 0, "R10");
        rd_chk(1, 1, "R10");
        wreg(0, 0); wreg(1, 0);
        cyc(2'b00, 2'b01, 0, 0, 0);
        rd_chk(0, 16'h00FF, "R10");
        rd_chk(1, 16'h00FF, "R10");
        rd_chk(4, 16'h0F00, "R10");
        wreg(5, 16'h0007);
        chk("R10", int'(irq_o[1]), 0, "irq1 joined");

        // constrained random phase against the model
        do_reset();
        model_on = 1;
        for (int n = 0; n < 4000; n++) begin
            int a;
            int wa;
            int wd;
            bit we;
            string tag;
            a = int'($urandom_range(0, 7));
            case (a)
                0, 1: tag = "R2";
                2, 3: tag = "R12";
                4, 5: tag = "R7";
                default: tag = "R10";
            endcase
            rd_chk(a, exp_reg(a), tag);
            chk("R8", int'(irq_o), exp_irq(), "irq");
            we = ($urandom_range(0, 5) == 0);
            wa = int'($urandom_range(0, 6));
            wd = int'($urandom_range(0, 65535));
            if (wa == 6 && $urandom_range(0, 3) != 0) wd = wd & 16'hFFFE;
            cyc(2'($urandom), 2'($urandom), we, wa, wd);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule